// File: doc/BRIEF.md
# Inter-Processor Doorbell Controller

This block is the notification point between a host processor and an offload microcontroller. Each side tells the other that work is waiting by raising a numbered channel. The block itself never looks at a message. The host reaches every control word and every storage word through one 32-bit register port. The remote side has two per-channel strobe inputs: one raises an incoming channel, the other releases a host doorbell once that doorbell has been taken.

When the host wants to ring the remote, it makes two writes. The first sets the busy bit of the channel. The second writes the channel number, and that write sends a one-cycle doorbell strobe to the remote. Incoming channels latch into a pending-flag register. These flags drive a level-high host interrupt through an enable mask, and they stay set until the host acknowledges them by writing a bit pattern.

Sixteen general words give the two sides a place to exchange ring base addresses, ring sizes and producer and consumer indices. They sit in two windows.

Top module: `mbox_doorbell_ctrl`

## Requirements
- R1: After reset, the following hold: `host_irq` is low, `rmt_db_valid` is low, the pending flags and busy bits read zero, every scratch word reads zero, and the IRQ0 enable word reads 0x00000082.
- R2: A write to offset 0x004 ORs `reg_wdata[7:0]` into the busy bits, and a read there returns them in bits 7:0. Busy bit n clears only when `rmt_busy_clr[n]` is high at a clock edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R3: A write to offset 0x00C makes `rmt_db_valid` high for exactly the one following cycle, with `rmt_db_chan` equal to `reg_wdata[2:0]`. A read of 0x00C returns the last channel written, in bits 2:0.
- R4: `rmt_raise[n]` high at a clock edge sets pending flag n at that edge. A read of offset 0x010 returns the pending flags in bits 7:0 and zero above them.
- R5: A write to offset 0x014 clears every pending flag whose bit is one in `reg_wdata[7:0]`. A remote raise on the same bit in the same cycle wins, and the flag stays set.
- R6: `host_irq` is high exactly while (pending flags AND IRQ0 enable bits) is nonzero. The IRQ0 enable word is at offset 0x018, bits 7:0, and its reset value enables channel 1 (remote message) and channel 7 (remote exception) only. So a raise of channel 0 alone leaves the interrupt low.
- R7: Writing zero to 0x018 drops `host_irq` in the cycle after the write, and the pending flags are kept.
- R8: Offsets 0x008 (start word) and 0x01C (IRQ1 enable word) each hold a full 32-bit value written by the host and read back unchanged.
- R9: The words at 0x020–0x03C and 0x050–0x06C (scratch in the lower half of each window, shadow in the upper half) are independent read/write 32-bit words.
- R10: Offsets that map to nothing (for example 0x000, 0x040, 0x070) read as zero, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe, one word per cycle |
| reg_addr | input | 12 | Host byte offset, for both read and write |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from `reg_addr` |
| rmt_raise | input | 8 | Remote raises incoming channel n (one bit per channel) |
| rmt_busy_clr | input | 8 | Remote releases busy bit n |
| rmt_db_valid | output | 1 | One-cycle doorbell strobe toward the remote |
| rmt_db_chan | output | 3 | Channel number carried by the doorbell strobe |
| host_irq | output | 1 | Level-high interrupt toward the host |

## Verification
The bench goes after two same-cycle collisions on a bit. The first is an acknowledge meeting a new raise: a design that lets the clear win silently loses a remote message. The second is a busy set meeting a busy release: a design that lets the release win leaves a fresh doorbell looking already taken. The bench also checks the following:
- Masking drops the interrupt at once but keeps the flags. A design that clears the flags there loses the pending channels, and one that registers the interrupt a second time fires one cycle late.
- A channel-0 raise must not interrupt under the reset mask.
- The unmapped holes between and after the windows must read zero and absorb writes. A loose decoder would alias them onto scratch words.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned MB_AW = 12;
  localparam int unsigned MB_DW = 32;

  localparam logic [MB_AW-1:0] OFS_BUSY  = 12'h004;
  localparam logic [MB_AW-1:0] OFS_START = 12'h008;
  localparam logic [MB_AW-1:0] OFS_TXCH  = 12'h00C;
  localparam logic [MB_AW-1:0] OFS_RXCH  = 12'h010;
  localparam logic [MB_AW-1:0] OFS_ACK   = 12'h014;
  localparam logic [MB_AW-1:0] OFS_MASK0 = 12'h018;
  localparam logic [MB_AW-1:0] OFS_MASK1 = 12'h01C;

  localparam logic [MB_AW-1:0] WIN_FIRST  = 12'h020;
  localparam logic [MB_AW-1:0] WIN_STRIDE = 12'h030;

  // Base byte offset of storage window b
  function automatic logic [MB_AW-1:0] win_base(input int unsigned b);
    return WIN_FIRST + MB_AW'(b) * WIN_STRIDE;
  endfunction

  // True when addr falls inside a window of nwords 32-bit words at base
  function automatic logic in_window(input logic [MB_AW-1:0] addr,
                                     input logic [MB_AW-1:0] base,
                                     input int unsigned nwords);
    return (addr >= base) && (addr < base + (MB_AW'(nwords) << 2));
  endfunction

  // Word index of addr relative to base
  function automatic logic [MB_AW-1:0] word_off(input logic [MB_AW-1:0] addr,
                                                input logic [MB_AW-1:0] base);
    return (addr - base) >> 2;
  endfunction

endpackage

// File: rtl/mbox_pending.sv
module mbox_pending #(
  parameter int unsigned CH_NUM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_NUM-1:0] raise_i,
  input  logic              ack_en,
  input  logic [CH_NUM-1:0] ack_bits,
  output logic [CH_NUM-1:0] flags_o
);

  logic [CH_NUM-1:0] flags_q;
  logic [CH_NUM-1:0] clr_vec;

  assign clr_vec = ack_en ? ack_bits : '0;

  // raise is ORed in after the clear, so a same-cycle raise wins
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | raise_i;
  end

  assign flags_o = flags_q;

  p_raise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_i) |=> ((flags_q & $past(raise_i)) == $past(raise_i)));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> ((flags_q & $past(ack_bits & ~raise_i)) == '0));

endmodule

// File: rtl/mbox_busy.sv
module mbox_busy #(
  parameter int unsigned CH_NUM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CH_NUM-1:0] set_bits,
  input  logic [CH_NUM-1:0] clr_i,
  output logic [CH_NUM-1:0] busy_o
);

  logic [CH_NUM-1:0] busy_q;
  logic [CH_NUM-1:0] set_vec;

  assign set_vec = set_en ? set_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_i) | set_vec;
  end

  assign busy_o = busy_q;

  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((busy_q & $past(set_bits)) == $past(set_bits)));

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((busy_q & $past(busy_q & ~clr_i)) == $past(busy_q & ~clr_i)));

endmodule

// File: rtl/mbox_scratch.sv
module mbox_scratch
  import mbox_pkg::*;
#(
  parameter int unsigned BANKS = 2,
  parameter int unsigned WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MB_AW-1:0] addr,
  input  logic [MB_DW-1:0] wdata,
  output logic             hit_o,
  output logic [MB_DW-1:0] rdata_o
);

  localparam int unsigned TOTAL = BANKS * WORDS;

  logic [MB_DW-1:0] word_q [TOTAL];
  logic [BANKS-1:0] bank_hit;
  logic [MB_AW-1:0] bank_off [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_hit[b] = in_window(addr, win_base(b), WORDS);
    assign bank_off[b] = word_off(addr, win_base(b));
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          word_q[b*WORDS+w] <= '0;
        else if (wr_en && bank_hit[b] && (bank_off[b] == MB_AW'(w)))
          word_q[b*WORDS+w] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < BANKS; b++)
      for (int w = 0; w < WORDS; w++)
        if (bank_hit[b] && (bank_off[b] == MB_AW'(w)))
          rdata_o = word_q[b*WORDS+w];
  end

  assign hit_o = |bank_hit;

  p_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

endmodule

// File: rtl/mbox_doorbell_ctrl.sv
module mbox_doorbell_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned CH_NUM   = 8,
  parameter int unsigned BANKS    = 2,
  parameter int unsigned WORDS    = 8,
  parameter logic [7:0]  MASK_RST = 8'h82
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [11:0]                reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [CH_NUM-1:0]          rmt_raise,
  input  logic [CH_NUM-1:0]          rmt_busy_clr,
  output logic                       rmt_db_valid,
  output logic [$clog2(CH_NUM)-1:0]  rmt_db_chan,
  output logic                       host_irq
);

  localparam int unsigned CIW = $clog2(CH_NUM);

  // named write events
  logic wr_busy, wr_start, wr_txch, wr_ack, wr_mask0, wr_mask1;
  assign wr_busy  = reg_wr && (reg_addr == OFS_BUSY);
  assign wr_start = reg_wr && (reg_addr == OFS_START);
  assign wr_txch  = reg_wr && (reg_addr == OFS_TXCH);
  assign wr_ack   = reg_wr && (reg_addr == OFS_ACK);
  assign wr_mask0 = reg_wr && (reg_addr == OFS_MASK0);
  assign wr_mask1 = reg_wr && (reg_addr == OFS_MASK1);

  logic [CH_NUM-1:0] pend_flags;
  logic [CH_NUM-1:0] busy_bits;
  logic [CH_NUM-1:0] mask0_q;
  logic [MB_DW-1:0]  mask1_q;
  logic [MB_DW-1:0]  start_q;
  logic [CIW-1:0]    txch_q;
  logic              db_valid_q;
  logic              scr_hit;
  logic [MB_DW-1:0]  scr_rdata;

  mbox_pending #(.CH_NUM(CH_NUM)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise_i  (rmt_raise),
    .ack_en   (wr_ack),
    .ack_bits (reg_wdata[CH_NUM-1:0]),
    .flags_o  (pend_flags)
  );

  mbox_busy #(.CH_NUM(CH_NUM)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (wr_busy),
    .set_bits (reg_wdata[CH_NUM-1:0]),
    .clr_i    (rmt_busy_clr),
    .busy_o   (busy_bits)
  );

  mbox_scratch #(.BANKS(BANKS), .WORDS(WORDS)) u_scratch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .hit_o   (scr_hit),
    .rdata_o (scr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask0_q    <= CH_NUM'(MASK_RST);
      mask1_q    <= '0;
      start_q    <= '0;
      txch_q     <= '0;
      db_valid_q <= 1'b0;
    end else begin
      if (wr_mask0) mask0_q <= reg_wdata[CH_NUM-1:0];
      if (wr_mask1) mask1_q <= reg_wdata;
      if (wr_start) start_q <= reg_wdata;
      if (wr_txch)  txch_q  <= reg_wdata[CIW-1:0];
      db_valid_q <= wr_txch;
    end
  end

  assign rmt_db_valid = db_valid_q;
  assign rmt_db_chan  = txch_q;
  assign host_irq     = |(pend_flags & mask0_q);

  always_comb begin
    unique case (reg_addr)
      OFS_BUSY:  reg_rdata = MB_DW'(busy_bits);
      OFS_START: reg_rdata = start_q;
      OFS_TXCH:  reg_rdata = MB_DW'(txch_q);
      OFS_RXCH:  reg_rdata = MB_DW'(pend_flags);
      OFS_MASK0: reg_rdata = MB_DW'(mask0_q);
      OFS_MASK1: reg_rdata = mask1_q;
      default:   reg_rdata = scr_hit ? scr_rdata : '0;
    endcase
  end

  p_doorbell_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txch |=> (rmt_db_valid && (rmt_db_chan == $past(reg_wdata[CIW-1:0]))));

  p_doorbell_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_txch |=> !rmt_db_valid);

  p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask0 && (reg_wdata[CH_NUM-1:0] == '0)) |=>
      (!host_irq && ((pend_flags & $past(pend_flags)) == $past(pend_flags))));

  p_hole_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h040 || reg_addr == 12'h000) |-> (reg_rdata == '0));

endmodule

// File: tb/mbox_doorbell_ctrl_bench.sv
module mbox_doorbell_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  rmt_raise = '0;
  logic [7:0]  rmt_busy_clr = '0;
  logic        rmt_db_valid;
  logic [2:0]  rmt_db_chan;
  logic        host_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbox_doorbell_ctrl u_mbox_doorbell_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .rmt_raise    (rmt_raise),
    .rmt_busy_clr (rmt_busy_clr),
    .rmt_db_valid (rmt_db_valid),
    .rmt_db_chan  (rmt_db_chan),
    .host_irq     (host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic raise(input logic [7:0] bits);
    @(negedge clk);
    rmt_raise = bits;
    @(negedge clk);
    rmt_raise = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(host_irq), 0);
    chk("R1 db_valid", 32'(rmt_db_valid), 0);
    rd(12'h018, d); chk("R1 mask0", d, 32'h82);
    rd(12'h010, d); chk("R1 pending", d, 0);
    rd(12'h004, d); chk("R1 busy", d, 0);
    rd(12'h020, d); chk("R1 scratch", d, 0);
    rd(12'h06C, d); chk("R1 shadow", d, 0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    wr(12'h004, 32'h01); rd(12'h004, d); chk("R2 set", d, 32'h01);
    wr(12'h004, 32'h08); rd(12'h004, d); chk("R2 or-set", d, 32'h09);
    @(negedge clk); rmt_busy_clr = 8'h01;
    @(negedge clk); rmt_busy_clr = 8'h00;
    rd(12'h004, d); chk("R2 clear ch0", d, 32'h08);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h08; rmt_busy_clr = 8'h08;
    @(negedge clk);
    reg_wr = 1'b0; rmt_busy_clr = 8'h00;
    rd(12'h004, d); chk("R2 set beats clear", d, 32'h08);
    @(negedge clk); rmt_busy_clr = 8'h08;
    @(negedge clk); rmt_busy_clr = 8'h00;
    rd(12'h004, d); chk("R2 clear ch3", d, 32'h00);
  endtask

  task automatic t_doorbell;
    logic [31:0] d;
    wr(12'h00C, 32'h5);
    chk("R3 pulse high", 32'(rmt_db_valid), 1);
    chk("R3 channel", 32'(rmt_db_chan), 5);
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(rmt_db_valid), 0);
    rd(12'h00C, d); chk("R3 readback", d, 5);
    wr(12'h00C, 32'h0);
    chk("R3 channel zero", {28'h0, rmt_db_valid, rmt_db_chan}, 32'h8);
  endtask

  task automatic t_pending_irq;
    logic [31:0] d;
    raise(8'h01);
    rd(12'h010, d); chk("R4 ch0 flag", d, 32'h01);
    chk("R6 ch0 masked off", 32'(host_irq), 0);
    raise(8'h80);
    rd(12'h010, d); chk("R4 ch7 flag", d, 32'h81);
    chk("R6 ch7 irq", 32'(host_irq), 1);
    wr(12'h014, 32'h80);
    chk("R6 irq after ack", 32'(host_irq), 0);
    rd(12'h010, d); chk("R5 partial ack", d, 32'h01);
    wr(12'h018, 32'h01);
    chk("R6 ch0 enabled", 32'(host_irq), 1);
    wr(12'h014, 32'h01);
    rd(12'h010, d); chk("R5 ack all", d, 0);
    wr(12'h018, 32'h82);
  endtask

  task automatic t_mask_zero;
    logic [31:0] d;
    raise(8'h02);
    chk("R6 ch1 irq", 32'(host_irq), 1);
    wr(12'h018, 32'h0);
    chk("R7 irq dropped", 32'(host_irq), 0);
    rd(12'h010, d); chk("R7 flags kept", d, 32'h02);
    wr(12'h018, 32'h82);
    chk("R6 irq back", 32'(host_irq), 1);
    wr(12'h014, 32'h02);
    chk("R5 irq cleared", 32'(host_irq), 0);
  endtask

  task automatic t_ack_race;
    logic [31:0] d;
    raise(8'h0A);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h014; reg_wdata = 32'h0A; rmt_raise = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; rmt_raise = 8'h00;
    rd(12'h010, d); chk("R5 raise beats ack", d, 32'h02);
    wr(12'h014, 32'h02);
    rd(12'h010, d); chk("R5 final clear", d, 0);
  endtask

  task automatic t_words;
    logic [31:0] d;
    wr(12'h008, 32'hDEADBEEF);
    wr(12'h01C, 32'h12345678);
    rd(12'h008, d); chk("R8 start", d, 32'hDEADBEEF);
    rd(12'h01C, d); chk("R8 mask1", d, 32'h12345678);
    chk("R8 no irq effect", 32'(host_irq), 0);
  endtask

  task automatic t_scratch;
    logic [31:0] d;
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 8; w++)
        wr(12'(32'h20 + b*32'h30 + w*4), 32'hA500_0000 | (b*16 + w));
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 8; w++) begin
        rd(12'(32'h20 + b*32'h30 + w*4), d);
        chk("R9 word", d, 32'hA500_0000 | (b*16 + w));
      end
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h000, 32'hFFFFFFFF);
    wr(12'h040, 32'hFFFFFFFF);
    wr(12'h070, 32'hFFFFFFFF);
    rd(12'h000, d); chk("R10 hole 0x000", d, 0);
    rd(12'h040, d); chk("R10 hole 0x040", d, 0);
    rd(12'h070, d); chk("R10 hole 0x070", d, 0);
    rd(12'h03C, d); chk("R10 0x03C intact", d, 32'hA500_0007);
    rd(12'h050, d); chk("R10 0x050 intact", d, 32'hA500_0010);
    rd(12'h06C, d); chk("R10 0x06C intact", d, 32'hA500_0017);
    rd(12'h020, d); chk("R10 0x020 intact", d, 32'hA500_0000);
    rd(12'h018, d); chk("R10 mask intact", d, 32'h82);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_busy;
    t_doorbell;
    t_pending_irq;
    t_mask_zero;
    t_ack_race;
    t_words;
    t_scratch;
    t_unmapped;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule